// File: doc/BRIEF.md
# Directory Coherence Controller

This block keeps the coherence directory for a group of caching nodes that share one main memory. For every memory block it records whether memory holds a current copy, which node last gained write ownership, and a bitmask of the nodes that hold a copy. Nodes report read misses and write misses on a request channel with a valid/ready handshake. Each miss ends with a single-cycle grant pulse back to the requesting node.

Before granting, the controller may have to act on the other nodes. A read miss on a block whose memory copy is stale sends a write-back request to the recorded owner. The grant then waits for the write-back completion. A write miss sends one invalidate command, carrying a bitmask, to every other copy holder. Each named node acknowledges on its own acknowledge bit, and the grant waits until every acknowledgement has arrived.

Only one transaction is in flight at a time. Data payloads, the network and cache replacement are handled elsewhere.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset every directory entry is valid, has an empty copy-set and has no owner, and `req_ready` is high while no output pulse is active.
- R2: A read miss (`req_write`=0) to a valid block raises `grant_valid` in the second cycle after the accepting clock edge, with no invalidate and no write-back request. The requester is added to the copy-set and all other copy-set bits are kept.
- R3: A read miss to a stale block raises `wb_req_valid` for one cycle, naming the recorded owner, in the cycle after acceptance. The grant is held until `wb_done` is sampled high. It then appears in the following cycle, and the block becomes valid with the requester added to the copy-set.
- R4: A write miss (`req_write`=1) raises `inv_valid` for one cycle, in the cycle after acceptance. `inv_mask` bit n names node n, and the mask equals the copy-set with the requester's bit removed.
- R5: After an invalidate, the grant is withheld until every node in `inv_mask` has pulsed its bit of `inv_ack` (bit n for node n). It appears in the cycle after the last acknowledgement is sampled.
- R6: After a write-miss grant, the copy-set holds only the requester, the owner is the requester, and the block is stale.
- R7: One request is handled at a time. `req_ready` is low from the accepting edge until the cycle after the grant, and the grant is a single-cycle pulse carrying the request's node, block and kind.
- R8: A write miss whose requester is the only copy holder, or whose copy-set is empty, is granted in the second cycle after acceptance with no invalidate.
- R9: A `wb_done` pulse while no write-back is awaited has no effect on the directory or on later grant timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Controller can accept a request |
| req_node | input | NID_W (2) | Requesting node |
| req_addr | input | ADDR_W (3) | Block index |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| grant_valid | output | 1 | Grant pulse |
| grant_node | output | NID_W (2) | Node being granted |
| grant_addr | output | ADDR_W (3) | Granted block |
| grant_write | output | 1 | 1 = write ownership granted |
| inv_valid | output | 1 | Invalidate command pulse |
| inv_mask | output | NODES (4) | Nodes to invalidate, bit n = node n |
| inv_addr | output | ADDR_W (3) | Block to invalidate |
| inv_ack | input | NODES (4) | Invalidate acknowledgements, bit n = node n |
| wb_req_valid | output | 1 | Write-back request pulse |
| wb_req_node | output | NID_W (2) | Node asked to write back |
| wb_req_addr | output | ADDR_W (3) | Block to write back |
| wb_done | input | 1 | Write-back completion |

## Verification
The assertions take three things for granted about the inputs. A node acknowledges an invalidate only while its bit is still outstanding. Acknowledgements never arrive in the cycle the invalidate is issued. A write-back completion that ends a wait arrives only after the write-back request. The bench keeps to this by acknowledging one outstanding node per cycle, in index order, after an optional gap. It raises `wb_done` only after a chosen delay inside the wait. Its single stray `wb_done` pulse is placed in an idle cycle, where the controller must ignore it.

// File: rtl/dirctl_pkg.sv
package dirctl_pkg;

    localparam int NODES  = 4;
    localparam int BLOCKS = 8;
    localparam int NID_W  = $clog2(NODES);
    localparam int ADDR_W = $clog2(BLOCKS);

    typedef logic [NODES-1:0]  nodeset_t;
    typedef logic [NID_W-1:0]  nid_t;
    typedef logic [ADDR_W-1:0] baddr_t;

    typedef struct packed {
        logic     valid;
        logic     has_owner;
        nid_t     owner;
        nodeset_t copies;
    } dir_entry_t;

    typedef struct packed {
        nid_t   node;
        baddr_t addr;
        logic   write;
    } dir_req_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISPATCH,
        ST_WAIT_WB,
        ST_WAIT_ACK,
        ST_RESPOND
    } ctl_state_t;

    function automatic nodeset_t node_bit(input nid_t n);
        nodeset_t b;
        b    = '0;
        b[n] = 1'b1;
        return b;
    endfunction

endpackage

// File: rtl/dir_store.sv
module dir_store
    import dirctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  baddr_t     rd_addr,
    output dir_entry_t rd_entry,
    input  logic       wr_en,
    input  baddr_t     wr_addr,
    input  dir_entry_t wr_entry
);
    dir_entry_t entries [BLOCKS];

    for (genvar b = 0; b < BLOCKS; b++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entries[b] <= '{valid: 1'b1, has_owner: 1'b0, owner: '0, copies: '0};
            end else if (wr_en && wr_addr == baddr_t'(b)) begin
                entries[b] <= wr_entry;
            end
        end
    end

    assign rd_entry = entries[rd_addr];

endmodule

// File: rtl/inv_tracker.sv
module inv_tracker
    import dirctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  nodeset_t load_mask,
    input  nodeset_t ack,
    output nodeset_t pending,
    output logic     all_acked
);
    always_ff @(posedge clk) begin
        if (rst)       pending <= '0;
        else if (load) pending <= load_mask;
        else           pending <= pending & ~ack;
    end

    assign all_acked = (pending & ~ack) == '0;

    AST_ACK_EXPECTED: assert property (@(posedge clk) disable iff (rst)
        (ack & ~pending) == '0);                                    // R5
    AST_LOAD_WHEN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        load |-> pending == '0);                                    // R5

endmodule

// File: rtl/dir_req_fsm.sv
module dir_req_fsm
    import dirctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  dir_req_t   req_in,
    output logic       req_ready,
    output dir_req_t   cur,
    input  dir_entry_t entry,
    input  logic       wb_done,
    input  logic       acks_done,
    output logic       inv_load,
    output nodeset_t   inv_mask,
    output logic       wb_req,
    output nid_t       wb_node,
    output logic       grant,
    output dir_entry_t dir_wdata
);
    ctl_state_t st, st_nx;
    nodeset_t   req_bit, others;

    assign req_bit = node_bit(cur.node);
    assign others  = entry.copies & ~req_bit;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:     if (req_valid) st_nx = ST_DISPATCH;
            ST_DISPATCH: begin
                if (cur.write) st_nx = (others != '0) ? ST_WAIT_ACK : ST_RESPOND;
                else           st_nx = entry.valid ? ST_RESPOND : ST_WAIT_WB;
            end
            ST_WAIT_WB:  if (wb_done) st_nx = ST_RESPOND;
            ST_WAIT_ACK: if (acks_done) st_nx = ST_RESPOND;
            ST_RESPOND:  st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cur <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && req_valid) cur <= req_in;
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign inv_load  = (st == ST_DISPATCH) && cur.write && (others != '0);
    assign inv_mask  = others;
    assign wb_req    = (st == ST_DISPATCH) && !cur.write && !entry.valid;
    assign wb_node   = entry.owner;
    assign grant     = (st == ST_RESPOND);

    always_comb begin
        if (cur.write) begin
            dir_wdata = '{valid: 1'b0, has_owner: 1'b1, owner: cur.node, copies: req_bit};
        end else begin
            dir_wdata = '{valid: 1'b1, has_owner: entry.has_owner, owner: entry.owner,
                          copies: entry.copies | req_bit};
        end
    end

    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);                   // R7
    AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (rst)
        grant |=> !grant);                                          // R7
    AST_WAIT_ONLY_STALE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT_WB) |-> !entry.valid);                       // R3
    AST_INV_PULSE: assert property (@(posedge clk) disable iff (rst)
        inv_load |=> !inv_load);                                    // R4

endmodule

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl
    import dirctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [NID_W-1:0]  req_node,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              grant_valid,
    output logic [NID_W-1:0]  grant_node,
    output logic [ADDR_W-1:0] grant_addr,
    output logic              grant_write,
    output logic              inv_valid,
    output logic [NODES-1:0]  inv_mask,
    output logic [ADDR_W-1:0] inv_addr,
    input  logic [NODES-1:0]  inv_ack,
    output logic              wb_req_valid,
    output logic [NID_W-1:0]  wb_req_node,
    output logic [ADDR_W-1:0] wb_req_addr,
    input  logic              wb_done
);
    dir_req_t   req_in, cur;
    dir_entry_t entry, wdata;
    nodeset_t   others, pending;
    logic       inv_load, acks_done, grant, wb_req;
    nid_t       wb_node;

    assign req_in = '{node: req_node, addr: req_addr, write: req_write};

    dir_req_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .req_ready (req_ready),
        .cur       (cur),
        .entry     (entry),
        .wb_done   (wb_done),
        .acks_done (acks_done),
        .inv_load  (inv_load),
        .inv_mask  (others),
        .wb_req    (wb_req),
        .wb_node   (wb_node),
        .grant     (grant),
        .dir_wdata (wdata)
    );

    dir_store u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_addr  (cur.addr),
        .rd_entry (entry),
        .wr_en    (grant),
        .wr_addr  (cur.addr),
        .wr_entry (wdata)
    );

    inv_tracker u_track (
        .clk       (clk),
        .rst       (rst),
        .load      (inv_load),
        .load_mask (others),
        .ack       (inv_ack),
        .pending   (pending),
        .all_acked (acks_done)
    );

    assign grant_valid  = grant;
    assign grant_node   = cur.node;
    assign grant_addr   = cur.addr;
    assign grant_write  = cur.write;
    assign inv_valid    = inv_load;
    assign inv_mask     = inv_load ? others : '0;
    assign inv_addr     = cur.addr;
    assign wb_req_valid = wb_req;
    assign wb_req_node  = wb_node;
    assign wb_req_addr  = cur.addr;

    AST_NO_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst)
        grant |-> pending == '0);                                   // R5
    AST_NO_OVERLAP_CMDS: assert property (@(posedge clk) disable iff (rst)
        !(inv_valid && wb_req_valid));                              // R4

endmodule

// File: tb/dir_coherence_ctrl_tb.sv
module dir_coherence_ctrl_tb;
    import dirctl_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, wb_done = 1'b0;
    logic [NID_W-1:0]  req_node = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [NODES-1:0]  inv_ack = '0;
    logic req_ready, grant_valid, grant_write, inv_valid, wb_req_valid;
    logic [NID_W-1:0]  grant_node, wb_req_node;
    logic [ADDR_W-1:0] grant_addr, inv_addr, wb_req_addr;
    logic [NODES-1:0]  inv_mask;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // behavioural directory image
    bit            m_valid  [BLOCKS];
    bit [NODES-1:0] m_copies [BLOCKS];
    int            m_owner  [BLOCKS];

    always #10 clk = ~clk;

    dir_coherence_ctrl u_dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic quiet(input string tag);
        chk_eq({tag, " grant"}, int'(grant_valid), 0);
        chk_eq({tag, " ready"}, int'(req_ready), 0);
        chk_eq({tag, " inv"}, int'(inv_valid), 0);
        chk_eq({tag, " wb"}, int'(wb_req_valid), 0);
    endtask

    // one miss, checked every cycle; gap = cycles before wb_done / first ack
    task automatic miss(input int node, input int addr, input bit wr, input int gap, input string tag);
        bit [NODES-1:0] others;
        bit [NODES-1:0] me;
        me = '0; me[node] = 1'b1;
        others = m_copies[addr] & ~me;
        chk_eq({"R7 ready before ", tag}, int'(req_ready), 1);
        req_valid = 1'b1; req_node = NID_W'(node); req_addr = ADDR_W'(addr); req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk_eq({"R7 busy ", tag}, int'(req_ready), 0);
        chk_eq({"R7 early grant ", tag}, int'(grant_valid), 0);
        if (wr) begin
            chk_eq({"R4 inv_valid ", tag}, int'(inv_valid), int'(others != 0));
            chk_eq({"R4 inv_mask ", tag}, int'(inv_mask), (others != 0) ? int'(others) : 0);
            if (others != 0) chk_eq({"R4 inv_addr ", tag}, int'(inv_addr), addr);
            chk_eq({"R8 no wb ", tag}, int'(wb_req_valid), 0);
            @(negedge clk);
            if (others != 0) begin
                repeat (gap) begin quiet({"R5 gap ", tag}); @(negedge clk); end
                for (int n = 0; n < NODES; n++) begin
                    if (others[n]) begin
                        inv_ack = '0; inv_ack[n] = 1'b1;
                        @(negedge clk);
                        inv_ack = '0;
                        if ((others >> (n + 1)) != 0) quiet({"R5 partial ack ", tag});
                    end
                end
            end
        end else begin
            chk_eq({"R2 no inv ", tag}, int'(inv_valid), 0);
            chk_eq({"R3 wb_req ", tag}, int'(wb_req_valid), int'(!m_valid[addr]));
            if (!m_valid[addr]) begin
                chk_eq({"R3 wb node ", tag}, int'(wb_req_node), m_owner[addr]);
                chk_eq({"R3 wb addr ", tag}, int'(wb_req_addr), addr);
                @(negedge clk);
                repeat (gap) begin quiet({"R3 held ", tag}); @(negedge clk); end
                wb_done = 1'b1;
                @(negedge clk);
                wb_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        chk_eq({"R7 grant ", tag}, int'(grant_valid), 1);
        chk_eq({"R7 grant node ", tag}, int'(grant_node), node);
        chk_eq({"R7 grant addr ", tag}, int'(grant_addr), addr);
        chk_eq({"R7 grant kind ", tag}, int'(grant_write), int'(wr));
        @(negedge clk);
        chk_eq({"R7 pulse end ", tag}, int'(grant_valid), 0);
        chk_eq({"R7 ready after ", tag}, int'(req_ready), 1);
        if (wr) begin
            m_copies[addr] = me; m_owner[addr] = node; m_valid[addr] = 1'b0;
        end else begin
            m_copies[addr] |= me; m_valid[addr] = 1'b1;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < BLOCKS; b++) begin m_valid[b] = 1; m_copies[b] = '0; m_owner[b] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs after reset
        chk_eq("R1 ready", int'(req_ready), 1);
        chk_eq("R1 grant", int'(grant_valid), 0);
        chk_eq("R1 inv", int'(inv_valid), 0);
        chk_eq("R1 wb", int'(wb_req_valid), 0);
        // R1/R2: fresh blocks are valid, no write-back needed
        miss(0, 0, 0, 0, "R1 fresh read b0");
        miss(1, 0, 0, 0, "R2 read b0 n1");
        miss(2, 0, 0, 0, "R2 read b0 n2");
        // R4/R5: invalidate nodes 0,1,2 with a gap before acks
        miss(3, 0, 1, 2, "R4 write b0 n3");
        // R6/R3: block now stale, owned by node 3
        miss(1, 0, 0, 2, "R6 stale read b0 n1");
        miss(1, 0, 1, 0, "R6 write b0 n1");
        // R8: sole holder writes again
        miss(1, 0, 1, 0, "R8 sole write b0");
        // R9: stray completion while idle is ignored
        wb_done = 1'b1;
        @(negedge clk);
        wb_done = 1'b0;
        chk_eq("R9 stray wb grant", int'(grant_valid), 0);
        chk_eq("R9 stray wb ready", int'(req_ready), 1);
        miss(2, 0, 0, 3, "R9 stale read after stray");
        // R8: empty copy-set write
        miss(0, 5, 1, 0, "R8 empty write b5");
        miss(3, 5, 0, 1, "R3 read b5 n3");
        // R2 on other blocks and patterns
        for (int b = 1; b < 4; b++) begin
            miss(b, b, 0, 0, "R2 sweep read");
            miss((b + 1) % NODES, b, 0, 0, "R2 sweep read2");
        end
        miss(0, 2, 1, 0, "R4 write b2 n0");
        miss(2, 5, 1, 1, "R5 write b5 n2");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule